// File: doc/BRIEF.md
# Multi-standard audio serial transmitter

This block is the transmit half of a master-mode audio serial port. It generates its own serial bit clock from the system clock, and it drives a word-select line and a serial data line. Samples arrive as 16-bit words over a valid/ready handshake. A sample wider than 16 bits is assembled from two consecutive words. The assembled sample is then placed inside a 16-bit or 32-bit channel slot, with the alignment and zero fill that the selected framing standard requires.

Two configuration inputs are held steady while the block runs and are changed only under reset. They select one of four framing standards and one of four data/channel packet types. In the three stereo standards, the left and right channels alternate, and the word-select line tells them apart. In the PCM standard, every slot carries the next sample, and the word-select line becomes a one-bit frame-sync pulse. If a channel slot begins before a complete sample has arrived, the block sends silence for that slot and latches an underrun indication.

Top module: `audio_ser_tx`

## Requirements
- R1: While reset is asserted and before the first serial clock edge, `sck`, `ws`, `sd` and `underrun` are low. `in_ready` is low while reset is applied.
- R2: `sck` idles low. It toggles every `HALF_DIV` system clock cycles, so one bit lasts 2*`HALF_DIV` cycles. `sd` and `ws` change only in the cycle where `sck` falls.
- R3: `fmt_pkt` selects the data and channel lengths: 0 gives 16-bit data in a 16-bit channel, 1 gives 16 in 32, 2 gives 24 in 32, and 3 gives 32 in 32. Every sample is sent most significant bit first.
- R4: Packet types 0 and 1 take one word per sample. Types 2 and 3 take two words, with the first word holding the upper 16 bits. For type 2, only bits [15:8] of the second word are used. `in_ready` stays low while a complete sample waits for its slot.
- R5: `fmt_std` 1 selects MSB-justified and 2 selects LSB-justified. In both, the left channel goes first with `ws` low, and the right channel follows with `ws` high. `ws` changes together with the first bit of each slot.
- R6: `fmt_std` 0 selects the Philips framing, with the same channel order and `ws` polarity as R5. `ws` changes one bit period before the first bit of each channel slot.
- R7: `fmt_std` 3 selects PCM. Each slot carries the next sample in order. `ws` is high for exactly the one bit that precedes the MSB of every slot after the first.
- R8: In standards 0, 1 and 3, a sample shorter than its 32-bit channel starts at the first bit of the slot, and zeros fill the rest of the slot.
- R9: In the LSB-justified standard, the sample is right-aligned in its slot so that its LSB is the last bit, and leading zeros fill the bits before it.
- R10: If no complete sample is held when a slot starts, the whole slot is sent as zeros, and `underrun` goes high and stays high until reset.
- R11: After reset, the bit period before the first falling edge of `sck` is a lead-in with `sd` and `ws` low. The first falling edge starts the left channel, or the first PCM slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_std | input | 2 | Framing standard: 0 Philips, 1 MSB-justified, 2 LSB-justified, 3 PCM |
| fmt_pkt | input | 2 | Packet type: 0 16/16, 1 16/32, 2 24/32, 3 32/32 (data/channel bits) |
| in_data | input | 16 | Sample word |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Block accepts `in_data` this cycle |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select (channel side) or PCM frame sync |
| sd | output | 1 | Serial data, MSB first |
| underrun | output | 1 | Sticky flag: a slot started without a sample |

## Verification
Assertions check several properties on every cycle:
- data and select change only when the serial clock falls;
- in the justified standards, word select moves only at a slot boundary;
- the padding bits of a 16-in-32 slot are zero, as are the leading bits of a right-aligned 24-bit slot;
- the underrun flag, once set, never clears.

The bench's scenarios show what no single-cycle property can: the exact bit stream per standard and packet type. This covers the Philips one-bit lead of word select, the PCM sync pulse position, the word order and the truncation of the second word, the right alignment, and the silent slots that follow a starved feeder.

// File: rtl/audio_ser_tx_pkg.sv
`timescale 1ns/1ps
package audio_ser_tx_pkg;

  localparam int WORD_W = 16;
  localparam int SLOT_W = 32;
  localparam int POS_W  = 6;

  typedef enum logic [1:0] {
    STD_PHILIPS = 2'd0,
    STD_MSBJ    = 2'd1,
    STD_LSBJ    = 2'd2,
    STD_PCM     = 2'd3
  } std_e;

  typedef enum logic [1:0] {
    PK_D16_C16 = 2'd0,
    PK_D16_C32 = 2'd1,
    PK_D24_C32 = 2'd2,
    PK_D32_C32 = 2'd3
  } pkt_e;

  function automatic logic [POS_W-1:0] slot_len(pkt_e p);
    return (p == PK_D16_C16) ? POS_W'(16) : POS_W'(SLOT_W);
  endfunction

  function automatic logic [POS_W-1:0] sample_len(pkt_e p);
    case (p)
      PK_D24_C32: return POS_W'(24);
      PK_D32_C32: return POS_W'(32);
      default:    return POS_W'(16);
    endcase
  endfunction

  function automatic logic needs_two(pkt_e p);
    return (p == PK_D24_C32) || (p == PK_D32_C32);
  endfunction

endpackage

// File: rtl/audio_ser_tx_clkgen.sv
`timescale 1ns/1ps
module audio_ser_tx_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sck,
  output logic fall_tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             wrap;

  always_comb begin
    wrap      = (cnt_q == CNT_LAST);
    cnt_d     = wrap ? '0 : cnt_q + 1'b1;
    sck_d     = wrap ? ~sck_q : sck_q;
    fall_tick = wrap && sck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck = sck_q;

  // R2: a falling tick is only ever issued while the bit clock is high
  a_r2_fall_from_high: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |=> !sck_q);

endmodule

// File: rtl/audio_ser_tx_loader.sv
`timescale 1ns/1ps
module audio_ser_tx_loader
  import audio_ser_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  std_e              std_sel,
  input  pkt_e              pkt_sel,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              take,
  output logic [SLOT_W-1:0] slot_bits,
  output logic              underrun
);
  logic [WORD_W-1:0] upper_q, upper_d;
  logic              half_q, half_d;
  logic [SLOT_W-1:0] stage_q, stage_d;
  logic              full_q, full_d;
  logic              urun_q, urun_d;
  logic              accept, complete, two;
  logic [SLOT_W-1:0] assembled;
  logic [POS_W-1:0]  rshift;

  always_comb begin
    two      = needs_two(pkt_sel);
    accept   = in_valid && !full_q;
    complete = accept && (!two || half_q);
    case (pkt_sel)
      PK_D24_C32: assembled = {upper_q, in_data[WORD_W-1:WORD_W-8], 8'h00};
      PK_D32_C32: assembled = {upper_q, in_data};
      default:    assembled = {in_data, {(SLOT_W-WORD_W){1'b0}}};
    endcase

    upper_d = upper_q;
    half_d  = half_q;
    stage_d = stage_q;
    full_d  = full_q;
    if (accept && two && !half_q) begin
      upper_d = in_data;
      half_d  = 1'b1;
    end
    if (take)     full_d = 1'b0;
    if (complete) begin
      stage_d = assembled;
      full_d  = 1'b1;
      half_d  = 1'b0;
    end
    urun_d = urun_q || (take && !full_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      half_q  <= 1'b0;
      stage_q <= '0;
      full_q  <= 1'b0;
      urun_q  <= 1'b0;
    end else begin
      upper_q <= upper_d;
      half_q  <= half_d;
      stage_q <= stage_d;
      full_q  <= full_d;
      urun_q  <= urun_d;
    end
  end

  // right alignment only in the LSB-justified standard with a wide slot
  always_comb begin
    rshift = '0;
    if (std_sel == STD_LSBJ)
      rshift = slot_len(pkt_sel) - sample_len(pkt_sel);
    slot_bits = full_q ? (stage_q >> rshift) : '0;
  end

  assign in_ready = rst_n && !full_q;
  assign underrun = urun_q;

  // R10: the underrun indication is sticky
  a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    urun_q |=> urun_q);

  // R4: a held sample is kept until its slot starts
  a_r4_hold_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> (full_q && $stable(stage_q)));

endmodule

// File: rtl/audio_ser_tx_framer.sv
`timescale 1ns/1ps
module audio_ser_tx_framer
  import audio_ser_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  std_e              std_sel,
  input  pkt_e              pkt_sel,
  input  logic              fall_tick,
  input  logic [SLOT_W-1:0] slot_bits,
  output logic              take,
  output logic              ws,
  output logic              sd
);
  logic              run_q;
  logic [POS_W-1:0]  pos_q, pos_nx;
  logic              ws_q, ws_nx;
  logic              sd_q, sd_nx;
  logic [SLOT_W-1:0] shf_q, shf_nx;
  logic [POS_W-1:0]  chan;
  logic [POS_W:0]    flen, ahead;
  logic              boundary;

  always_comb begin
    chan = slot_len(pkt_sel);
    flen = (std_sel == STD_PCM) ? {1'b0, chan} : {chan, 1'b0};

    if (!run_q)                          pos_nx = '0;
    else if ({1'b0, pos_q} == flen - 1'b1) pos_nx = '0;
    else                                 pos_nx = pos_q + 1'b1;

    boundary = ((pos_nx & (chan - 1'b1)) == '0);
    take     = fall_tick && boundary;

    ahead = ({1'b0, pos_nx} == flen - 1'b1) ? '0 : {1'b0, pos_nx} + 1'b1;
    case (std_sel)
      STD_PHILIPS: ws_nx = (ahead >= {1'b0, chan});
      STD_PCM:     ws_nx = (pos_nx == chan - 1'b1);
      default:     ws_nx = (pos_nx >= chan);
    endcase

    if (boundary) begin
      sd_nx  = slot_bits[SLOT_W-1];
      shf_nx = {slot_bits[SLOT_W-2:0], 1'b0};
    end else begin
      sd_nx  = shf_q[SLOT_W-1];
      shf_nx = {shf_q[SLOT_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pos_q <= '0;
      ws_q  <= 1'b0;
      sd_q  <= 1'b0;
      shf_q <= '0;
    end else if (fall_tick) begin
      run_q <= 1'b1;
      pos_q <= pos_nx;
      ws_q  <= ws_nx;
      sd_q  <= sd_nx;
      shf_q <= shf_nx;
    end
  end

  assign ws = ws_q;
  assign sd = sd_q;

  // R8: the zero pad after a 16-bit sample in a 32-bit slot
  a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && std_sel != STD_LSBJ && pkt_sel == PK_D16_C32 && pos_q[4:0] >= 5'd16)
      |-> !sd_q);

  // R9: leading zeros before a right-aligned 24-bit sample
  a_r9_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && std_sel == STD_LSBJ && pkt_sel == PK_D24_C32 && pos_q[4:0] < 5'd8)
      |-> !sd_q);

  // R11: position stays inside the frame
  a_r11_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pos_q} < flen);

endmodule

// File: rtl/audio_ser_tx.sv
`timescale 1ns/1ps
module audio_ser_tx
  import audio_ser_tx_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_std,
  input  logic [1:0]        fmt_pkt,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              sck,
  output logic              ws,
  output logic              sd,
  output logic              underrun
);
  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  std_e              std_sel;
  pkt_e              pkt_sel;
  logic              fall_tick;
  logic              take_w;
  logic [SLOT_W-1:0] slot_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign std_sel = std_e'(fmt_std);
  assign pkt_sel = pkt_e'(fmt_pkt);

  audio_ser_tx_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_ni),
    .sck       (sck),
    .fall_tick (fall_tick)
  );

  audio_ser_tx_loader u_loader (
    .clk       (clk),
    .rst_n     (rst_ni),
    .std_sel   (std_sel),
    .pkt_sel   (pkt_sel),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .take      (take_w),
    .slot_bits (slot_bits),
    .underrun  (underrun)
  );

  audio_ser_tx_framer u_framer (
    .clk       (clk),
    .rst_n     (rst_ni),
    .std_sel   (std_sel),
    .pkt_sel   (pkt_sel),
    .fall_tick (fall_tick),
    .slot_bits (slot_bits),
    .take      (take_w),
    .ws        (ws),
    .sd        (sd)
  );

  // R2: data moves only on a falling bit clock
  a_r2_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(sd) |-> ($past(sck) && !sck));

  // R2: select moves only on a falling bit clock
  a_r2_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(ws) |-> ($past(sck) && !sck));

  // R5: in the justified standards select toggles only where a slot begins
  a_r5_ws_at_slot: assert property (@(posedge clk) disable iff (!rst_ni)
    ((std_sel == STD_MSBJ || std_sel == STD_LSBJ) && !$stable(ws)) |-> $past(take_w));

endmodule

// File: tb/audio_ser_tx_bench.sv
`timescale 1ns/1ps
module audio_ser_tx_bench;
  localparam int HALF = 2;

  logic        clk;
  logic        rst_n;
  logic [1:0]  fmt_std, fmt_pkt;
  logic [15:0] in_data;
  logic        in_valid;
  logic        in_ready, sck, ws, sd, underrun;

  int n_cmp, n_bad, cyc, widx, wlim;
  bit feed_go, acc;

  audio_ser_tx #(.HALF_DIV(HALF)) u_audio_ser_tx (
    .clk(clk), .rst_n(rst_n), .fmt_std(fmt_std), .fmt_pkt(fmt_pkt),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .sck(sck), .ws(ws), .sd(sd), .underrun(underrun)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] sample_val(int s);
    return (32'(s) + 32'd1) * 32'h9E37_79B1 + 32'h0000_1357;
  endfunction

  function automatic logic [15:0] word_of(int w);
    logic [31:0] v;
    if (fmt_pkt < 2'd2) begin
      v = sample_val(w);
      return v[15:0];
    end
    v = sample_val(w / 2);
    return (w % 2 == 0) ? v[31:16] : v[15:0];
  endfunction

  function automatic logic [31:0] data_of(int s);
    logic [31:0] v;
    v = sample_val(s);
    case (fmt_pkt)
      2'd2:    return {8'h00, v[31:8]};
      2'd3:    return v;
      default: return {16'h0000, v[15:0]};
    endcase
  endfunction

  task automatic check(string tag, int k, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s std=%0d pkt=%0d bit=%0d: actual %0b expected %0b",
               tag, fmt_std, fmt_pkt, k, act, exp);
    end
  endtask

  // feeder: presents words in order while enabled and under the limit
  initial begin
    in_valid = 1'b0;
    in_data  = '0;
    acc      = 1'b0;
    forever begin
      @(negedge clk);
      if (acc) widx++;
      acc = 1'b0;
      if (feed_go && widx < wlim) begin
        in_valid = 1'b1;
        in_data  = word_of(widx);
        acc      = in_ready;
      end else begin
        in_valid = 1'b0;
      end
    end
  end

  task automatic run_cfg(int st, int pk, int lim, int nbits);
    int cl, dl, off, last;
    fmt_std = 2'(st);
    fmt_pkt = 2'(pk);
    cl  = (pk == 0) ? 16 : 32;
    dl  = (pk == 2) ? 24 : (pk == 3) ? 32 : 16;
    off = (st == 2) ? cl - dl : 0;
    rst_n   = 1'b0;
    feed_go = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    widx = 0;
    wlim = lim * ((pk >= 2) ? 2 : 1);
    // R1: reset state
    check("R1 sck", 0, sck, 1'b0);
    check("R1 ws", 0, ws, 1'b0);
    check("R1 sd", 0, sd, 1'b0);
    check("R1 in_ready", 0, in_ready, 1'b0);
    check("R1 underrun", 0, underrun, 1'b0);
    rst_n   = 1'b1;
    feed_go = 1'b1;
    last = -1;
    for (int k = 0; k < nbits; k++) begin
      int j, c, b;
      logic ews, esd, eur;
      logic [31:0] dv;
      string tw, td;
      @(posedge sck);
      #1;
      if (last >= 0) check("R2 period", k, (cyc - last) == 2 * HALF, 1'b1);
      last = cyc;
      if (k == 0) begin
        check("R11 lead-in ws", k, ws, 1'b0);
        check("R11 lead-in sd", k, sd, 1'b0);
        check("R10 underrun", k, underrun, 1'b0);
        continue;
      end
      j = k - 1;
      c = j / cl;
      b = j % cl;
      case (st)
        0:       begin ews = 1'(((j + 1) / cl) % 2); tw = "R6 ws"; end
        3:       begin ews = (b == cl - 1);          tw = "R7 ws"; end
        default: begin ews = 1'(c % 2);              tw = "R5 ws"; end
      endcase
      dv  = data_of(c);
      esd = 1'b0;
      if (c >= lim) td = "R10 sd";
      else if (b >= off && b - off < dl) begin
        esd = dv[dl - 1 - (b - off)];
        td  = (pk >= 2) ? "R4 sd" : "R3 sd";
      end else td = (st == 2) ? "R9 sd" : "R8 sd";
      eur = (c + 1 > lim);
      check(tw, k, ws, ews);
      check(td, k, sd, esd);
      check("R10 underrun", k, underrun, eur);
    end
    feed_go = 1'b0;
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0; widx = 0; wlim = 0;
    feed_go = 1'b0;
    rst_n = 1'b0;
    fmt_std = '0;
    fmt_pkt = '0;
    for (int st = 0; st < 4; st++)
      for (int pk = 0; pk < 4; pk++)
        run_cfg(st, pk, 1000, 1 + 6 * ((pk == 0) ? 16 : 32));
    // R10: starved feeder, stereo and PCM
    run_cfg(0, 1, 3, 1 + 6 * 32);
    run_cfg(3, 2, 2, 1 + 5 * 32);
    run_cfg(2, 0, 1, 1 + 4 * 16);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule